// File: doc/BRIEF.md
# Cache-Operation Access Protection Checker

This block sits at the memory stage of a pipeline and judges each memory-management operation that arrives there: cache maintenance, cache touches, cache debug reads and indexed string loads and stores. For each request it decides whether the operation goes ahead, is quietly dropped as a no-op, raises a data storage interrupt, or raises a TLB-miss interrupt. The decision uses the operation's class, the translation-enable bit, the TLB lookup outcome, the write-enable bit of the matched TLB entry, the two-bit zone field picked for the access, the privilege mode and the string byte count.

Each class has its own fixed profile. The profile records whether the class behaves as a store or as a load, whether it is privileged, whether it is a speculative hint, whether it names a specific address, and whether it is a string operation. A small decoder turns the class code into this profile. A combinational judge applies the rules in a fixed priority order. A register stage then presents one verdict per request, one cycle later, together with a valid flag.

Top module: `op_access_guard`

## Requirements
- R1: The verdict is a 2-bit code: 00 proceed, 01 no-op, 10 data storage interrupt, 11 TLB miss. `rsp_valid` equals `req_valid` of the previous cycle, and `rsp_verdict` shows the verdict for the request presented one cycle earlier. When no request is presented, `rsp_verdict` holds its last value.
- R2: A synchronous active-high reset drives `rsp_valid` to 0 and `rsp_verdict` to 00.
- R3: Class codes are: 0 data congruence-class invalidate, 1 data touch, 2 data touch-for-store, 3 data flush, 4 data clean, 5 data debug read, 6 instruction debug read, 7 instruction block invalidate, 8 instruction touch, 9 instruction congruence-class invalidate, 10 string load, 11 string store. Codes 12 to 15 always give proceed.
- R4: With translation disabled, every class gives proceed, except a zero-length string operation.
- R5: With translation enabled and a TLB miss, these classes give TLB miss (11): the non-speculative classes that name a specific address (0, 3, 4, 7, 8, 9, and 10 or 11 with a nonzero count). The miss wins over any data storage condition in the same request.
- R6: The touch classes 1 and 2 never give TLB miss or data storage interrupt. A TLB miss, or a user-mode access to zone 00, turns them into a no-op (01). Write-enable 0 has no effect on them.
- R7: The store-like classes 0 and 11 (the latter with a nonzero count) give data storage interrupt when translation is on, the TLB hits and write-enable is 0. This holds in any mode and any zone.
- R8: The unprivileged loads 3, 4, 7 and 10 (nonzero count) give data storage interrupt when translation is on, the TLB hits, the mode is user and the zone is 00. Write-enable 0 does not fault them.
- R9: The privileged classes 0, 5, 6, 8 and 9 are never faulted by zone 00, in either mode.
- R10: The debug reads 5 and 6 address no specific location. They give proceed for every combination of the other inputs.
- R11: String classes 10 and 11 with a byte count of 0 give no-op (01) regardless of every other input.
- R12: Zone 00 faults only in user mode. Zone values 01, 10 and 11 never cause a zone fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_class | input | 4 | Operation class code |
| xlat_en | input | 1 | Data address translation enabled |
| tlb_hit | input | 1 | TLB lookup matched |
| tlb_wr_en | input | 1 | Write-enable bit of the matched TLB entry |
| zone | input | 2 | Zone protection field for the access |
| user_mode | input | 1 | 1 = user mode, 0 = supervisor mode |
| byte_cnt | input | BC_W (7) | String transfer byte count |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_verdict | output | 2 | Verdict code |

## Verification
Two rules can both apply to the same request. A TLB miss can coincide with a write-protect or zone condition. A zone-00 denial can coincide with the suppression of a speculative touch. The bench provokes both cases by driving a miss together with write-enable 0 and user-mode zone 00 on store-like and address-specific classes. It then requires code 11 for those classes, and code 01 for touches that meet a miss or a zone denial. An exhaustive sweep of every class against every flag combination is compared with an independent reference rule. Directed entries pin the priority cases by hand.

// File: rtl/opguard_pkg.sv
package opguard_pkg;

    localparam int CLASS_W = 4;
    localparam int VERD_W  = 2;

    typedef enum logic [CLASS_W-1:0] {
        OPC_DCONG_INV = 4'd0,
        OPC_DTOUCH    = 4'd1,
        OPC_DTOUCH_WR = 4'd2,
        OPC_DFLUSH    = 4'd3,
        OPC_DCLEAN    = 4'd4,
        OPC_DDBG_RD   = 4'd5,
        OPC_IDBG_RD   = 4'd6,
        OPC_IBLK_INV  = 4'd7,
        OPC_ITOUCH    = 4'd8,
        OPC_ICONG_INV = 4'd9,
        OPC_STR_LD    = 4'd10,
        OPC_STR_ST    = 4'd11
    } op_class_e;

    typedef enum logic [VERD_W-1:0] {
        VERD_GO   = 2'b00,
        VERD_NOP  = 2'b01,
        VERD_DSI  = 2'b10,
        VERD_TLBM = 2'b11
    } verdict_e;

    // Static profile of an operation class
    typedef struct packed {
        logic known;       // class code is defined
        logic is_store;    // checked against TLB write-enable
        logic privileged;  // exempt from zone denial
        logic speculative; // faults collapse into a no-op
        logic specific;    // names an address, so a TLB miss matters
        logic strop;       // length-controlled string operation
    } op_attr_t;

    function automatic op_attr_t class_attr(logic [CLASS_W-1:0] code);
        op_attr_t a;
        a = '0;
        case (code)
            OPC_DCONG_INV: a = '{known:1'b1, is_store:1'b1, privileged:1'b1,
                                 speculative:1'b0, specific:1'b1, strop:1'b0};
            OPC_DTOUCH,
            OPC_DTOUCH_WR: a = '{known:1'b1, is_store:1'b0, privileged:1'b0,
                                 speculative:1'b1, specific:1'b1, strop:1'b0};
            OPC_DFLUSH,
            OPC_DCLEAN,
            OPC_IBLK_INV:  a = '{known:1'b1, is_store:1'b0, privileged:1'b0,
                                 speculative:1'b0, specific:1'b1, strop:1'b0};
            OPC_DDBG_RD,
            OPC_IDBG_RD:   a = '{known:1'b1, is_store:1'b0, privileged:1'b1,
                                 speculative:1'b0, specific:1'b0, strop:1'b0};
            OPC_ITOUCH,
            OPC_ICONG_INV: a = '{known:1'b1, is_store:1'b0, privileged:1'b1,
                                 speculative:1'b0, specific:1'b1, strop:1'b0};
            OPC_STR_LD:    a = '{known:1'b1, is_store:1'b0, privileged:1'b0,
                                 speculative:1'b0, specific:1'b1, strop:1'b1};
            OPC_STR_ST:    a = '{known:1'b1, is_store:1'b1, privileged:1'b0,
                                 speculative:1'b0, specific:1'b1, strop:1'b1};
            default:       a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/opg_decode.sv
module opg_decode
    import opguard_pkg::*;
(
    input  logic [CLASS_W-1:0] cls,
    output op_attr_t           attr
);
    always_comb begin
        attr = class_attr(cls);
    end
endmodule

// File: rtl/opg_judge.sv
module opg_judge
    import opguard_pkg::*;
(
    input  op_attr_t attr,
    input  logic     xlat_en,
    input  logic     tlb_hit,
    input  logic     tlb_wr_en,
    input  logic [1:0] zone,
    input  logic     user_mode,
    input  logic     bc_zero,
    output verdict_e verdict
);
    logic zone_deny;

    always_comb begin
        zone_deny = (zone == 2'b00) && user_mode && !attr.privileged;
        verdict   = VERD_GO;
        if (!attr.known) begin
            verdict = VERD_GO;
        end else if (attr.strop && bc_zero) begin
            verdict = VERD_NOP;
        end else if (!xlat_en) begin
            verdict = VERD_GO;
        end else if (!tlb_hit) begin
            if (attr.speculative)   verdict = VERD_NOP;
            else if (attr.specific) verdict = VERD_TLBM;
            else                    verdict = VERD_GO;
        end else if (attr.is_store && !tlb_wr_en) begin
            verdict = VERD_DSI;
        end else if (zone_deny) begin
            verdict = attr.speculative ? VERD_NOP : VERD_DSI;
        end
    end
endmodule

// File: rtl/opg_outreg.sv
module opg_outreg
    import opguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  verdict_e          in_verdict,
    output logic              out_valid,
    output logic [VERD_W-1:0] out_verdict
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_verdict <= VERD_GO;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_verdict <= in_verdict;
        end
    end
endmodule

// File: rtl/op_access_guard.sv
module op_access_guard
    import opguard_pkg::*;
#(
    parameter int BC_W = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [3:0]      req_class,
    input  logic            xlat_en,
    input  logic            tlb_hit,
    input  logic            tlb_wr_en,
    input  logic [1:0]      zone,
    input  logic            user_mode,
    input  logic [BC_W-1:0] byte_cnt,
    output logic            rsp_valid,
    output logic [1:0]      rsp_verdict
);
    op_attr_t attr;
    verdict_e verdict_c;
    logic     bc_zero;

    assign bc_zero = (byte_cnt == '0);

    opg_decode u_dec (
        .cls  (req_class),
        .attr (attr)
    );

    opg_judge u_judge (
        .attr      (attr),
        .xlat_en   (xlat_en),
        .tlb_hit   (tlb_hit),
        .tlb_wr_en (tlb_wr_en),
        .zone      (zone),
        .user_mode (user_mode),
        .bc_zero   (bc_zero),
        .verdict   (verdict_c)
    );

    opg_outreg u_reg (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (req_valid),
        .in_verdict  (verdict_c),
        .out_valid   (rsp_valid),
        .out_verdict (rsp_verdict)
    );
endmodule

// File: rtl/opg_checker.sv
module opg_checker #(
    parameter int BC_W = 7
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [3:0]      req_class,
    input logic            xlat_en,
    input logic            tlb_hit,
    input logic            tlb_wr_en,
    input logic [1:0]      zone,
    input logic            user_mode,
    input logic [BC_W-1:0] byte_cnt,
    input logic            rsp_valid,
    input logic [1:0]      rsp_verdict
);
    logic is_str, is_touch, is_dbg, silent_zone;
    assign is_str      = (req_class == 4'd10) || (req_class == 4'd11);
    assign is_touch    = (req_class == 4'd1) || (req_class == 4'd2);
    assign is_dbg      = (req_class == 4'd5) || (req_class == 4'd6);
    assign silent_zone = (req_class == 4'd0) || (req_class == 4'd8) || (req_class == 4'd9);

    assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_valid_drop_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(rsp_verdict));
    assert_reset_clear_R2: assert property (@(posedge clk)
        rst |=> (!rsp_valid && rsp_verdict == 2'b00));
    assert_high_codes_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_class >= 4'd12) |=> rsp_verdict == 2'b00);
    assert_xlat_off_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !xlat_en && !is_str) |=> rsp_verdict == 2'b00);
    assert_touch_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_touch) |=> rsp_verdict[1] == 1'b0);
    assert_priv_zone_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && silent_zone && tlb_hit && tlb_wr_en) |=> rsp_verdict == 2'b00);
    assert_dbg_go_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_dbg) |=> rsp_verdict == 2'b00);
    assert_str_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_str && byte_cnt == '0) |=> rsp_verdict == 2'b01);
endmodule

bind op_access_guard opg_checker #(.BC_W(BC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_class   (req_class),
    .xlat_en     (xlat_en),
    .tlb_hit     (tlb_hit),
    .tlb_wr_en   (tlb_wr_en),
    .zone        (zone),
    .user_mode   (user_mode),
    .byte_cnt    (byte_cnt),
    .rsp_valid   (rsp_valid),
    .rsp_verdict (rsp_verdict)
);

// File: tb/sim_op_access_guard.sv
`timescale 1ns/1ps
module sim_op_access_guard;
    localparam int BC_W = 7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic [3:0]      req_class = '0;
    logic            xlat_en = 1'b0, tlb_hit = 1'b0, tlb_wr_en = 1'b0, user_mode = 1'b0;
    logic [1:0]      zone = '0;
    logic [BC_W-1:0] byte_cnt = '0;
    logic            rsp_valid;
    logic [1:0]      rsp_verdict;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    op_access_guard #(.BC_W(BC_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
        .xlat_en(xlat_en), .tlb_hit(tlb_hit), .tlb_wr_en(tlb_wr_en), .zone(zone),
        .user_mode(user_mode), .byte_cnt(byte_cnt),
        .rsp_valid(rsp_valid), .rsp_verdict(rsp_verdict)
    );

    typedef struct packed {
        logic [3:0]      cls;
        logic            x;
        logic            h;
        logic            w;
        logic [1:0]      z;
        logic            u;
        logic [BC_W-1:0] bc;
        logic [1:0]      exp;
    } vec_t;

    // Hand-computed priority and corner cases
    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{4'd0,  1'b1,1'b1,1'b0,2'b00,1'b0,7'd5,2'b10}, // R7 supervisor store fault
        '{4'd0,  1'b1,1'b0,1'b0,2'b00,1'b1,7'd5,2'b11}, // R5 miss beats DSI
        '{4'd1,  1'b1,1'b0,1'b0,2'b00,1'b1,7'd5,2'b01}, // R6 touch on miss
        '{4'd2,  1'b1,1'b1,1'b0,2'b00,1'b1,7'd5,2'b01}, // R6 touch zone deny
        '{4'd1,  1'b1,1'b1,1'b0,2'b01,1'b1,7'd5,2'b00}, // R6 we=0 ignored
        '{4'd3,  1'b1,1'b1,1'b0,2'b01,1'b1,7'd5,2'b00}, // R8 flush not write-checked
        '{4'd4,  1'b1,1'b1,1'b1,2'b00,1'b1,7'd5,2'b10}, // R8 clean zone fault
        '{4'd4,  1'b1,1'b1,1'b1,2'b00,1'b0,7'd5,2'b00}, // R12 supervisor zone 00
        '{4'd5,  1'b1,1'b0,1'b0,2'b00,1'b1,7'd5,2'b00}, // R10 debug read
        '{4'd9,  1'b1,1'b1,1'b0,2'b00,1'b1,7'd5,2'b00}, // R9 icongr no DSI
        '{4'd9,  1'b1,1'b0,1'b1,2'b11,1'b0,7'd5,2'b11}, // R5 icongr miss
        '{4'd11, 1'b1,1'b0,1'b0,2'b00,1'b1,7'd0,2'b01}, // R11 zero string store
        '{4'd11, 1'b1,1'b1,1'b0,2'b10,1'b0,7'd5,2'b10}, // R7 string store write fault
        '{4'd10, 1'b0,1'b0,1'b0,2'b00,1'b1,7'd5,2'b00}, // R4 translation off
        '{4'd7,  1'b1,1'b1,1'b1,2'b00,1'b1,7'd5,2'b10}, // R8 block invalidate
        '{4'd8,  1'b1,1'b1,1'b1,2'b00,1'b1,7'd5,2'b00}, // R9 itouch privileged
        '{4'd13, 1'b1,1'b0,1'b0,2'b00,1'b1,7'd5,2'b00}  // R3 undefined code
    };

    // Reference rule written from the requirements
    function automatic logic [1:0] ref_verdict(input logic [3:0] c, input logic x,
            input logic h, input logic w, input logic [1:0] z, input logic u,
            input logic bc0);
        logic touch, dbg, unpriv, storeish;
        touch    = (c == 4'd1) || (c == 4'd2);
        dbg      = (c == 4'd5) || (c == 4'd6);
        storeish = (c == 4'd0) || (c == 4'd11);
        unpriv   = touch || (c == 4'd3) || (c == 4'd4) || (c == 4'd7) ||
                   (c == 4'd10) || (c == 4'd11);
        if (c > 4'd11) return 2'b00;                      // R3
        if ((c == 4'd10 || c == 4'd11) && bc0) return 2'b01; // R11
        if (!x) return 2'b00;                             // R4
        if (!h) return touch ? 2'b01 : (dbg ? 2'b00 : 2'b11); // R5 R6 R10
        if (storeish && !w) return 2'b10;                 // R7
        if (z == 2'b00 && u && unpriv) return touch ? 2'b01 : 2'b10; // R8 R12
        return 2'b00;                                     // R9
    endfunction

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic x, input logic h,
            input logic w, input logic [1:0] z, input logic u, input logic [BC_W-1:0] bc);
        req_valid = 1'b1; req_class = c; xlat_en = x; tlb_hit = h;
        tlb_wr_en = w; zone = z; user_mode = u; byte_cnt = bc;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 50000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset valid", {1'b0, rsp_valid}, 2'b00);
        chk("R2 reset verdict", rsp_verdict, 2'b00);

        // Directed table, back-to-back
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].cls, TBL[i].x, TBL[i].h, TBL[i].w, TBL[i].z, TBL[i].u, TBL[i].bc);
            @(negedge clk);
            chk("R1 valid", {1'b0, rsp_valid}, 2'b01);
            chk($sformatf("table %0d", i), rsp_verdict, TBL[i].exp);
        end

        // Exhaustive sweep against the reference rule
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < 128; k++) begin
                logic [1:0] e;
                e = ref_verdict(4'(c), k[0], k[1], k[2], k[4:3], k[5], k[6]);
                drive(4'(c), k[0], k[1], k[2], k[4:3], k[5], k[6] ? 7'd0 : 7'd9);
                @(negedge clk);
                chk($sformatf("sweep R3-class %0d combo %0d", c, k), rsp_verdict, e);
            end
        end

        // R1 hold: produce a DSI then idle with changed inputs
        drive(4'd0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 7'd3);
        @(negedge clk);
        chk("R7 setup", rsp_verdict, 2'b10);
        req_valid = 1'b0; req_class = 4'd5; tlb_wr_en = 1'b1;
        @(negedge clk);
        chk("R1 idle valid low", {1'b0, rsp_valid}, 2'b00);
        chk("R1 verdict held", rsp_verdict, 2'b10);
        @(negedge clk);
        chk("R1 verdict still held", rsp_verdict, 2'b10);

        // R11 byte count of one is not zero-length
        drive(4'd10, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 7'd1);
        @(negedge clk);
        chk("R11 count one faults as miss (R5)", rsp_verdict, 2'b11);
        drive(4'd10, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 7'd0);
        @(negedge clk);
        chk("R11 count zero no-op", rsp_verdict, 2'b01);

        // R2 mid-run reset with nonzero verdict
        rst = 1'b1;
        @(negedge clk);
        chk("R2 mid reset valid", {1'b0, rsp_valid}, 2'b00);
        chk("R2 mid reset verdict", rsp_verdict, 2'b00);
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk("R2 after reset idle", {1'b0, rsp_valid}, 2'b00);

        done = 1'b1;
        report();
        $finish;
    end
endmodule